// File: doc/BRIEF.md
# Strap-Latched Clock Divider Controller

This block is the digital control core of a system clock generator. Four shared pads do two jobs. While power-on reset is held, the pads are inputs that carry board-level configuration straps. On the first reference edge after reset is released, the block stores the pad levels in a configuration register and freezes it. One cycle later, the block takes the pads over as clock outputs.

The stored code picks the operating mode, and one 3-bit value is reserved for production test. In test mode the block derives clocks from the reference by dividing it by 1, 2, 3 and 4, and routes them to fixed output groups. In every other mode the divided outputs stay low. The block then presents the latched code to a downstream synthesizer:
- a CPU rate index, which picks one of eight rates;
- a bus flag: synchronous, at half the CPU rate, or asynchronous, at a fixed rate.

The internal clock runs at twice the reference rate, so one reference period lasts `REF_TICKS` = 2 internal ticks. All waveforms below are stated in ticks. The block carries no data stream, so it has no valid/ready interface. Every pin is a plain level-sensitive control or clock signal.

Top module: `strap_clk_ctrl`

## Requirements
- R1: While `por_n_i` is low at a clock edge, the block is in its reset state:
  - `pad_oe_o` and `pad_out_o` are all zero;
  - every clock output is low;
  - `cfg_valid_o` is 0;
  - `{cpu_rate_o, bus_sync_o}` reads 4'hF, which is the unstrapped pull-up default.
- R2: At the first clock edge with `por_n_i` high, the block captures `pad_in_i` and sets `cfg_valid_o`. After that edge, `cpu_rate_o` equals `pad_in_i[3:1]` and `bus_sync_o` equals `pad_in_i[0]`, where 1 means a bus at half the CPU rate and 0 means a fixed asynchronous bus rate.
- R3: Once captured, the configuration code does not change, whatever `pad_in_i` does, until the next reset.
- R4: `pad_oe_o` goes to all ones exactly one clock after capture. While it is low, `pad_out_o` is zero.
- R5: `test_mode_o` is 1 exactly when the latched rate index equals 3'b011.
- R6: In test mode, `ref_clk_o` and `pad_out_o[0]` form a divide-by-1 reference clock, high for 1 tick out of every 2.
- R7: In test mode, `fix_hi_clk_o` is REF/2 (high 2 ticks of 4) and `fix_lo_clk_o` is REF/4 (high 4 ticks of 8).
- R8: In test mode, `cpu_clk_o` and `pad_out_o[3:1]` are REF/2. `bus_clk_o` is REF/4 when the latched bus flag is 1, and REF/3 (high 3 ticks of 6) when it is 0.
- R9: All test clocks start high together in the first tick after the pads are enabled.
- R10: Outside test mode, all clock outputs and `pad_out_o` stay low while the pads are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock, twice the reference rate |
| por_n_i | input | 1 | Power-on reset, active low, sampled synchronously |
| pad_in_i | input | 4 | Pad levels: bit 0 is the bus flag, bits 3:1 are the rate index |
| pad_out_o | output | 4 | Pad drive: bit 0 is the reference clock, bits 3:1 are the CPU clock |
| pad_oe_o | output | 4 | Pad output enables |
| ref_clk_o | output | 1 | Test reference clock, divide by 1 |
| fix_hi_clk_o | output | 1 | Test fixed clock, divide by 2 |
| fix_lo_clk_o | output | 1 | Test fixed clock, divide by 4 |
| cpu_clk_o | output | 1 | Test CPU clock, divide by 2 |
| bus_clk_o | output | 1 | Test bus clock, divide by 4 or 3 |
| test_mode_o | output | 1 | Latched code selects test mode |
| cfg_valid_o | output | 1 | Configuration captured |
| cpu_rate_o | output | 3 | Latched CPU rate index for the synthesizer |
| bus_sync_o | output | 1 | Latched bus flag, 1 for synchronous |

## Verification
The hardest situation to reach is a pad that keeps changing after capture while the configuration must stay frozen. The single cycle between capture and output enable is also hard to catch, because it is the only one in which the code is valid and the pads are still undriven. The bench releases reset on a falling edge, so it knows the capture edge exactly. It samples that one-cycle window, and then drives fresh random values on the pads every cycle while it checks both the code and the waveforms. Only 2 of the 16 codes enter test mode, so half of the random trials are forced onto the test index, with a random bus flag.

// File: rtl/strap_clk_pkg.sv
package strap_clk_pkg;
  localparam int unsigned STRAP_W  = 4;
  localparam int unsigned RATE_W   = STRAP_W - 1;
  localparam int unsigned N_DIVS   = 4;
  localparam logic [RATE_W-1:0] TEST_SEL = 3'b011;

  // packed so that rate sits on pad bits 3:1 and the bus flag on pad bit 0
  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              sync;
  } strap_t;
endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import strap_clk_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic [STRAP_W-1:0] pin_i,
  output strap_t             code_o,
  output logic               captured_o,
  output logic               oe_o
);
  always_ff @(posedge clk) begin
    if (!por_n) begin
      code_o     <= strap_t'({STRAP_W{1'b1}});
      captured_o <= 1'b0;
      oe_o       <= 1'b0;
    end else begin
      if (!captured_o) begin
        code_o     <= strap_t'(pin_i);
        captured_o <= 1'b1;
      end
      oe_o <= captured_o;
    end
  end

  // R3: frozen after capture
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!por_n)
    captured_o |=> $stable(code_o));

  // R4: pads are never enabled ahead of capture
  assert_oe_lag_R4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(oe_o) |-> $past(captured_o));
endmodule

// File: rtl/clk_div.sv
module clk_div #(
  parameter int unsigned DIV = 2,
  parameter int unsigned TPR = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic run_i,
  output logic clk_o
);
  localparam int unsigned PER = DIV * TPR;
  localparam int unsigned HI  = PER / 2;
  localparam int unsigned W   = (PER > 2) ? $clog2(PER) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!por_n || !run_i) cnt <= '0;
    else if (cnt == W'(PER - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign clk_o = run_i && (cnt < W'(HI));

  // R9: each divider starts in its high phase
  assert_start_high_R9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(run_i) |-> clk_o);

  // R8: a running divider returns to phase zero only after a full period
  assert_period_R8: assert property (@(posedge clk) disable iff (!por_n)
    (run_i && $past(run_i) && cnt == '0) |-> ($past(cnt) == W'(PER - 1)));
endmodule

// File: rtl/test_clk_gen.sv
module test_clk_gen
  import strap_clk_pkg::*;
#(
  parameter int unsigned TPR = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              run_i,
  output logic [N_DIVS-1:0] div_o
);
  // div_o[i] is the reference divided by i+1; all share run and reset
  for (genvar gi = 0; gi < N_DIVS; gi++) begin : g_div
    clk_div #(.DIV(gi + 1), .TPR(TPR)) u_div (
      .clk   (clk),
      .por_n (por_n),
      .run_i (run_i),
      .clk_o (div_o[gi])
    );
  end
endmodule

// File: rtl/strap_clk_ctrl.sv
module strap_clk_ctrl
  import strap_clk_pkg::*;
#(
  parameter int unsigned REF_TICKS = 2
) (
  input  logic               clk_i,
  input  logic               por_n_i,
  input  logic [STRAP_W-1:0] pad_in_i,
  output logic [STRAP_W-1:0] pad_out_o,
  output logic [STRAP_W-1:0] pad_oe_o,
  output logic               ref_clk_o,
  output logic               fix_hi_clk_o,
  output logic               fix_lo_clk_o,
  output logic               cpu_clk_o,
  output logic               bus_clk_o,
  output logic               test_mode_o,
  output logic               cfg_valid_o,
  output logic [RATE_W-1:0]  cpu_rate_o,
  output logic               bus_sync_o
);
  strap_t            code;
  logic              captured, oe, is_test, run;
  logic [N_DIVS-1:0] div;

  strap_latch u_latch (
    .clk        (clk_i),
    .por_n      (por_n_i),
    .pin_i      (pad_in_i),
    .code_o     (code),
    .captured_o (captured),
    .oe_o       (oe)
  );

  assign is_test = (code.rate == TEST_SEL);
  assign run     = oe && is_test;

  test_clk_gen #(.TPR(REF_TICKS)) u_gen (
    .clk   (clk_i),
    .por_n (por_n_i),
    .run_i (run),
    .div_o (div)
  );

  assign ref_clk_o    = div[0];
  assign fix_hi_clk_o = div[1];
  assign fix_lo_clk_o = div[3];
  assign cpu_clk_o    = div[1];
  assign bus_clk_o    = code.sync ? div[3] : div[2];

  assign pad_oe_o    = {STRAP_W{oe}};
  assign pad_out_o   = oe ? {{(STRAP_W-1){cpu_clk_o}}, ref_clk_o} : '0;
  assign test_mode_o = is_test;
  assign cfg_valid_o = captured;
  assign cpu_rate_o  = code.rate;
  assign bus_sync_o  = code.sync;

  // R4: undriven pads carry no clock
  assert_pad_quiet_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !pad_oe_o[0] |-> (pad_out_o == '0));

  // R10: normal mode keeps every clock output low
  assert_norm_quiet_R10: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (pad_oe_o[0] && !test_mode_o) |->
      (pad_out_o == '0 && !bus_clk_o && !fix_lo_clk_o && !fix_hi_clk_o));
endmodule

// File: tb/strap_clk_ctrl_tb_top.sv
module strap_clk_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [3:0] pad_in = 4'hF;
  logic [3:0] pad_out, pad_oe;
  logic       ref_c, fhi, flo, cpu_c, bus_c, tmode, cvalid, bsync;
  logic [2:0] crate;
  int         errors = 0;
  int         checks = 0;

  always #2 clk = ~clk;

  strap_clk_ctrl dut_i (
    .clk_i        (clk),
    .por_n_i      (por_n),
    .pad_in_i     (pad_in),
    .pad_out_o    (pad_out),
    .pad_oe_o     (pad_oe),
    .ref_clk_o    (ref_c),
    .fix_hi_clk_o (fhi),
    .fix_lo_clk_o (flo),
    .cpu_clk_o    (cpu_c),
    .bus_clk_o    (bus_c),
    .test_mode_o  (tmode),
    .cfg_valid_o  (cvalid),
    .cpu_rate_o   (crate),
    .bus_sync_o   (bsync)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // divide-by-n waveform, k ticks after enable, two ticks per reference period
  function automatic logic div_wave(input int n, input int k);
    return (k % (2 * n)) < n;
  endfunction

  task automatic trial(input logic [3:0] s, input int ticks);
    logic is_t;
    logic e_ref, e_hi, e_lo, e_cpu, e_bus;
    is_t = (s[3:1] == 3'b011);
    @(negedge clk);
    por_n  = 1'b0;
    pad_in = s;
    repeat (3) @(negedge clk);
    chk("R1 oe", {28'd0, pad_oe}, 32'd0);
    chk("R1 pad", {28'd0, pad_out}, 32'd0);
    chk("R1 clocks", {27'd0, ref_c, fhi, flo, cpu_c, bus_c}, 32'd0);
    chk("R1 code", {27'd0, cvalid, crate, bsync}, 32'h0F);
    por_n = 1'b1;
    @(negedge clk);
    chk("R2 code", {27'd0, cvalid, crate, bsync}, {27'd0, 1'b1, s});
    chk("R4 window oe", {28'd0, pad_oe}, 32'd0);
    chk("R4 window pad", {28'd0, pad_out}, 32'd0);
    chk("R5 mode", {31'd0, tmode}, {31'd0, is_t});
    pad_in = 4'($urandom);
    @(negedge clk);
    chk("R4 oe", {28'd0, pad_oe}, 32'hF);
    for (int k = 0; k < ticks; k++) begin
      e_ref = is_t && div_wave(1, k);
      e_hi  = is_t && div_wave(2, k);
      e_lo  = is_t && div_wave(4, k);
      e_cpu = is_t && div_wave(2, k);
      e_bus = is_t && (s[0] ? div_wave(4, k) : div_wave(3, k));
      chk("R3 frozen", {28'd0, crate, bsync}, {28'd0, s});
      if (is_t) begin
        chk("R6 ref", {31'd0, ref_c}, {31'd0, e_ref});
        chk("R7 fixed", {30'd0, fhi, flo}, {30'd0, e_hi, e_lo});
        chk("R8 cpu/bus", {30'd0, cpu_c, bus_c}, {30'd0, e_cpu, e_bus});
        chk("R6 R8 pads", {28'd0, pad_out}, {28'd0, e_cpu, e_cpu, e_cpu, e_ref});
        if (k == 0) chk("R9 aligned", {27'd0, ref_c, fhi, flo, cpu_c, bus_c}, 32'h1F);
      end else begin
        chk("R10 quiet", {23'd0, pad_out, ref_c, fhi, flo, cpu_c, bus_c}, 32'd0);
      end
      pad_in = 4'($urandom);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] s;
    void'($urandom(32'd20250611));
    trial(4'b0111, 30);   // test mode, synchronous bus: bus REF/4
    trial(4'b0110, 30);   // test mode, asynchronous bus: bus REF/3
    trial(4'b1111, 12);   // unstrapped pads read as all ones
    trial(4'b0000, 12);
    trial(4'b1110, 12);
    for (int t = 0; t < 24; t++) begin
      s = 4'($urandom);
      if ($urandom % 2 == 0) s[3:1] = 3'b011;
      trial(s, 26);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule